// File: doc/BRIEF.md
# Voltage-to-Current Bridge Gate Translator

This block sits behind a three-phase voltage-source modulator. It turns the modulator's three upper-switch states and its dc-side switch command into the six gate commands of a current-source bridge, plus the gate of the current-source dc switch. Each of the six active voltage vectors has exactly one current-source code. Each code turns on one upper device and one lower device, and the two devices belong to different legs.

The two zero vectors carry no voltage information. The block replaces them with a "shorted-leg" code, which turns on both devices of one leg. The leg is chosen by a pointer that moves to the next leg once per carrier period, so that the conduction loss of the freewheeling intervals is shared between the legs.

The current-source dc switch is the complement of the voltage-source dc command, but it may conduct only while a shorted-leg code is applied. A request to close it during an active vector is treated as a fault. In that case the block emits the current shorted-leg code with the dc switch open.

All outputs leave a register. Every emitted gate word has two bits set, so the dc current always has a path.

Top module: `csi_gate_mapper`

## Requirements
- R1: While reset is high and in the first output after it, the gate word is 100100 (leg A shorted), the dc switch output is 0 and the fault flag is 0.
- R2: All outputs are registered. The outputs after a rising edge reflect the inputs sampled at that edge.
- R3: Gate word bit order, MSB first, is {upper A, upper B, upper C, lower A, lower B, lower C}. Input `vsi_upper` holds phase A in bit 2, B in bit 1 and C in bit 0. The active vectors map as follows: 100→100001, 110→010001, 010→010100, 011→001100, 001→001010, 101→100010.
- R4: For a zero vector (000 or 111), the dc switch output equals the inverse of `vsi_dc`.
- R5: The dc switch output is 1 only while the gate word is a shorted-leg code, that is, when its upper three bits equal its lower three bits.
- R6: A zero vector produces the shorted-leg code of the selected leg: leg A 100100, leg B 010010, leg C 001001.
- R7: The selected leg starts at A after reset. It advances A→B→C→A at each rising edge where `carrier_tick` is 1 and reset is low, and it holds otherwise. An output produced at a tick edge uses the leg selected before the advance.
- R8: An active vector sampled with `vsi_dc` = 0 produces `fault` = 1, the selected shorted-leg code and a dc switch output of 0.
- R9: Every gate word emitted has exactly two bits set, including across any change between active and zero vectors.
- R10: The fault flag is 0 in any output whose sampled inputs are legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsi_upper | input | 3 | Modulator upper-switch states, A in bit 2 |
| vsi_dc | input | 1 | Modulator dc-side switch command |
| carrier_tick | input | 1 | One-cycle pulse per carrier period |
| csi_gate | output | 6 | Bridge gate word {UA,UB,UC,LA,LB,LC} |
| csi_dc | output | 1 | Current-source dc switch gate |
| fault | output | 1 | Illegal request seen in the sampled inputs |

## Verification
The bench builds the block with its default parameters: three legs and the rotating selection policy. With those defaults, three carrier ticks carry the leg pointer through every shorted-leg code and back to leg A, so the wrap of the pointer and all three substitute codes appear within a few cycles. Because the set of vectors is so small, all eight of them can be applied with both dc commands, and they can be chained back to back to exercise every active/zero boundary.

// File: rtl/csi_map_pkg.sv
package csi_map_pkg;
  typedef enum logic [1:0] {
    CHK_OK        = 2'd0,
    CHK_DC_ACTIVE = 2'd1,
    CHK_BAD_COUNT = 2'd2
  } chk_cause_t;
endpackage

// File: rtl/vsi_vector_decode.sv
module vsi_vector_decode #(
  parameter int NUM_LEGS = 3,
  localparam int GW = 2 * NUM_LEGS
) (
  input  logic [NUM_LEGS-1:0] upper,
  output logic [GW-1:0]       active_word,
  output logic                is_null
);
  logic [NUM_LEGS-1:0] s;
  logic [NUM_LEGS-1:0] up_on;
  logic [NUM_LEGS-1:0] lo_on;

  // Leg p conducts on top when it is high and its successor low,
  // and on the bottom for the opposite pattern.
  for (genvar p = 0; p < NUM_LEGS; p++) begin : g_leg
    localparam int NXT = (p + 1) % NUM_LEGS;
    assign s[p]     = upper[NUM_LEGS-1-p];
    assign up_on[p] = upper[NUM_LEGS-1-p] & ~upper[NUM_LEGS-1-NXT];
    assign lo_on[p] = ~upper[NUM_LEGS-1-p] & upper[NUM_LEGS-1-NXT];
    assign active_word[GW-1-p]       = up_on[p];
    assign active_word[NUM_LEGS-1-p] = lo_on[p];
  end

  assign is_null = (&s) | ~(|s);
endmodule

// File: rtl/null_leg_selector.sv
module null_leg_selector #(
  parameter int NUM_LEGS  = 3,
  parameter bit ROTATE    = 1'b1,
  parameter int FIXED_LEG = 0,
  localparam int GW    = 2 * NUM_LEGS,
  localparam int PTR_W = (NUM_LEGS > 1) ? $clog2(NUM_LEGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [PTR_W-1:0] leg,
  output logic [GW-1:0]    null_word
);
  if (ROTATE) begin : g_rotate
    logic [PTR_W-1:0] ptr_q;
    always_ff @(posedge clk) begin
      if (rst)
        ptr_q <= '0;
      else if (tick)
        ptr_q <= (ptr_q == PTR_W'(NUM_LEGS - 1)) ? '0 : ptr_q + 1'b1;
    end
    assign leg = ptr_q;

    // R7: pointer advances by one leg, with wrap, on a tick
    a_r7_advance: assert property (@(posedge clk) disable iff (rst)
      tick |=> (leg == (($past(leg) == PTR_W'(NUM_LEGS - 1)) ? '0 : $past(leg) + 1'b1)));
    // R7: pointer holds without a tick
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(leg));
    // R6: pointer always names an existing leg
    a_r6_leg_range: assert property (@(posedge clk) disable iff (rst)
      leg < PTR_W'(NUM_LEGS));
  end else begin : g_fixed
    logic unused_in;
    assign unused_in = clk ^ rst ^ tick;
    assign leg = PTR_W'(FIXED_LEG);
  end

  for (genvar p = 0; p < NUM_LEGS; p++) begin : g_code
    assign null_word[GW-1-p]       = (leg == PTR_W'(p));
    assign null_word[NUM_LEGS-1-p] = (leg == PTR_W'(p));
  end
endmodule

// File: rtl/gate_guard.sv
module gate_guard
  import csi_map_pkg::*;
#(
  parameter int NUM_LEGS = 3,
  localparam int GW    = 2 * NUM_LEGS,
  localparam int CNT_W = $clog2(GW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] active_word,
  input  logic          is_null,
  input  logic          dc_req,
  input  logic [GW-1:0] null_word,
  output logic [GW-1:0] gate_q,
  output logic          dc_q,
  output logic          fault_q
);
  localparam logic [GW-1:0] RST_WORD =
    (GW'(1) << (GW - 1)) | (GW'(1) << (NUM_LEGS - 1));

  logic [GW-1:0]    cand;
  logic             cand_dc;
  logic [CNT_W-1:0] ones;
  chk_cause_t       cause;

  always_comb begin
    cand    = is_null ? null_word : active_word;
    cand_dc = is_null & dc_req;
    ones    = '0;
    for (int i = 0; i < GW; i++) ones = ones + CNT_W'(cand[i]);
    if (!is_null && dc_req)
      cause = CHK_DC_ACTIVE;
    else if (ones != CNT_W'(2))
      cause = CHK_BAD_COUNT;
    else
      cause = CHK_OK;
  end

  // A single register stage replaces the whole word at once.
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= RST_WORD;
      dc_q    <= 1'b0;
      fault_q <= 1'b0;
    end else if (cause != CHK_OK) begin
      gate_q  <= null_word;
      dc_q    <= 1'b0;
      fault_q <= 1'b1;
    end else begin
      gate_q  <= cand;
      dc_q    <= cand_dc;
      fault_q <= 1'b0;
    end
  end

  // R9: never an open current path
  a_r9_two_bits: assert property (@(posedge clk) disable iff (rst)
    $countones(gate_q) == 2);
  // R5: dc switch closes only over a shorted leg
  a_r5_dc_null_only: assert property (@(posedge clk) disable iff (rst)
    dc_q |-> (gate_q[GW-1:NUM_LEGS] == gate_q[NUM_LEGS-1:0]));
  // R8: illegal request is flagged and the dc switch is kept open
  a_r8_fault_flag: assert property (@(posedge clk) disable iff (rst)
    (!is_null && dc_req) |=> (fault_q && !dc_q));
  // R8: fault output is a shorted-leg code
  a_r8_fault_safe: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> (gate_q[GW-1:NUM_LEGS] == gate_q[NUM_LEGS-1:0]));
  // R4: dc request on a zero vector passes through
  a_r4_dc_pass: assert property (@(posedge clk) disable iff (rst)
    (is_null && dc_req) |=> dc_q);
endmodule

// File: rtl/csi_gate_mapper.sv
module csi_gate_mapper #(
  parameter int NUM_LEGS  = 3,
  parameter bit ROTATE    = 1'b1,
  parameter int FIXED_LEG = 0,
  localparam int GW    = 2 * NUM_LEGS,
  localparam int PTR_W = (NUM_LEGS > 1) ? $clog2(NUM_LEGS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_LEGS-1:0] vsi_upper,
  input  logic                vsi_dc,
  input  logic                carrier_tick,
  output logic [GW-1:0]       csi_gate,
  output logic                csi_dc,
  output logic                fault
);
  logic [GW-1:0]    active_word;
  logic [GW-1:0]    null_word;
  logic             is_null;
  logic [PTR_W-1:0] leg;

  vsi_vector_decode #(.NUM_LEGS(NUM_LEGS)) u_decode (
    .upper       (vsi_upper),
    .active_word (active_word),
    .is_null     (is_null)
  );

  null_leg_selector #(
    .NUM_LEGS  (NUM_LEGS),
    .ROTATE    (ROTATE),
    .FIXED_LEG (FIXED_LEG)
  ) u_select (
    .clk       (clk),
    .rst       (rst),
    .tick      (carrier_tick),
    .leg       (leg),
    .null_word (null_word)
  );

  gate_guard #(.NUM_LEGS(NUM_LEGS)) u_guard (
    .clk         (clk),
    .rst         (rst),
    .active_word (active_word),
    .is_null     (is_null),
    .dc_req      (~vsi_dc),
    .null_word   (null_word),
    .gate_q      (csi_gate),
    .dc_q        (csi_dc),
    .fault_q     (fault)
  );

  // R10: a legal input never raises the flag on the next output
  a_r10_no_false_fault: assert property (@(posedge clk) disable iff (rst)
    (is_null || vsi_dc) |=> !fault);
endmodule

// File: tb/sim_csi_gate_mapper.sv
module sim_csi_gate_mapper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] vsi_upper = 3'b000;
  logic       vsi_dc = 1'b1;
  logic       carrier_tick = 1'b0;
  logic [5:0] csi_gate;
  logic       csi_dc;
  logic       fault;

  int n_checks = 0;
  int n_fails  = 0;
  int exp_leg  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  csi_gate_mapper u0 (
    .clk(clk), .rst(rst), .vsi_upper(vsi_upper), .vsi_dc(vsi_dc),
    .carrier_tick(carrier_tick), .csi_gate(csi_gate), .csi_dc(csi_dc),
    .fault(fault)
  );

  function automatic logic [5:0] leg_code(int l);
    case (l)
      0: return 6'b100100;
      1: return 6'b010010;
      default: return 6'b001001;
    endcase
  endfunction

  function automatic logic [5:0] active_code(logic [2:0] u);
    case (u)
      3'b100: return 6'b100001;
      3'b110: return 6'b010001;
      3'b010: return 6'b010100;
      3'b011: return 6'b001100;
      3'b001: return 6'b001010;
      3'b101: return 6'b100010;
      default: return 6'b000000;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, look at the next falling edge.
  task automatic step(logic [2:0] u, logic sw, logic tk, string req);
    logic [5:0] ew;
    logic       ed, ef;
    bit         nul;
    nul = (u == 3'b000) || (u == 3'b111);
    if (nul) begin
      ew = leg_code(exp_leg); ed = ~sw; ef = 1'b0;
    end else if (!sw) begin
      ew = leg_code(exp_leg); ed = 1'b0; ef = 1'b1;
    end else begin
      ew = active_code(u); ed = 1'b0; ef = 1'b0;
    end
    vsi_upper = u; vsi_dc = sw; carrier_tick = tk;
    @(negedge clk);
    if (tk) exp_leg = (exp_leg + 1) % 3;
    check(csi_gate == ew, req, "gate", int'(csi_gate), int'(ew));
    check(csi_dc == ed, req, "dc", int'(csi_dc), int'(ed));
    check(fault == ef, req, "fault", int'(fault), int'(ef));
    check($countones(csi_gate) == 2, "R9", "bits set", $countones(csi_gate), 2);
  endtask

  task automatic t_reset;
    carrier_tick = 1'b1;
    vsi_upper = 3'b110;
    repeat (3) @(negedge clk);
    check(csi_gate == 6'b100100, "R1", "reset gate", int'(csi_gate), 6'b100100);
    check(csi_dc == 1'b0, "R1", "reset dc", int'(csi_dc), 0);
    check(fault == 1'b0, "R1", "reset fault", int'(fault), 0);
    rst = 1'b0;
    exp_leg = 0;
    step(3'b000, 1'b1, 1'b0, "R1");
  endtask

  task automatic t_active;
    step(3'b100, 1'b1, 1'b0, "R3");
    step(3'b110, 1'b1, 1'b0, "R3");
    step(3'b010, 1'b1, 1'b0, "R3");
    step(3'b011, 1'b1, 1'b0, "R3");
    step(3'b001, 1'b1, 1'b0, "R3");
    step(3'b101, 1'b1, 1'b0, "R2");
  endtask

  task automatic t_null_dc;
    step(3'b000, 1'b0, 1'b0, "R4");
    step(3'b111, 1'b0, 1'b0, "R4");
    step(3'b111, 1'b1, 1'b0, "R4");
    step(3'b000, 1'b1, 1'b0, "R6");
  endtask

  task automatic t_rotate;
    step(3'b000, 1'b0, 1'b1, "R7");
    step(3'b111, 1'b0, 1'b0, "R7");
    step(3'b000, 1'b1, 1'b1, "R7");
    step(3'b000, 1'b0, 1'b0, "R6");
    step(3'b100, 1'b1, 1'b1, "R7");
    step(3'b111, 1'b1, 1'b0, "R7");
    step(3'b111, 1'b1, 1'b0, "R7");
  endtask

  task automatic t_fault;
    step(3'b010, 1'b0, 1'b0, "R8");
    step(3'b101, 1'b0, 1'b1, "R8");
    step(3'b011, 1'b0, 1'b0, "R8");
    step(3'b011, 1'b1, 1'b0, "R10");
    step(3'b000, 1'b0, 1'b0, "R10");
  endtask

  task automatic t_transitions;
    logic [2:0] seq [8] = '{3'b000, 3'b100, 3'b110, 3'b111, 3'b010,
                            3'b011, 3'b000, 3'b001};
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 8; i++) begin
        step(seq[i], (i % 2 == 0) ? 1'b0 : 1'b1, (i == 3) ? 1'b1 : 1'b0, "R5");
      end
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_active();
    t_null_dc();
    t_rotate();
    t_fault();
    t_transitions();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule